// File: doc/BRIEF.md
# Dual-Channel Integrating Conversion Sequencer

The sequencer counts single-cycle pulse events on two input channels over one shared integration window, measured in clock cycles. Both channel counters start and stop on the same clock edge. When a window closes, both totals move into their result registers on the same edge, a one-cycle marker goes high for interrupt logic, and the next window starts on the following cycle with cleared counters. No host action is needed between windows.

A host reads the two 16-bit results through a byte-wide port. Reading a channel's low byte captures that channel's high byte into a holding register. A later read of the high byte returns the captured value, so a result read byte by byte is always coherent, even if a transfer happens between the two reads. While the enable input is low the counters stay at zero, no window runs, and the result registers keep their values.

Top module: `dual_integ_seq`

## Requirements
- R1: Both channel counters integrate over the same window of N clock cycles, where N is the programmed length (a programmed 0 counts as 1). A channel adds one for each rising clock edge at which its pulse input and enable are both high.
- R2: On the edge that closes a window, both result registers load their channel's window total together. `xfer_done` is high for exactly the cycle in which the new values first appear, and it is low in every other cycle.
- R3: The next window starts on the cycle right after a transfer, with both counters at zero and no idle cycle.
- R4: Each counter saturates at 0xFFFF instead of wrapping, and a saturated total is transferred as 0xFFFF.
- R5: The programmed length is sampled when a window starts (and continuously while disabled). A change made during a window takes effect from the next window only.
- R6: `rd_data` shows the selected byte combinationally. `rd_addr` 0 selects the channel 0 low byte, 1 the channel 0 high byte, 2 the channel 1 low byte and 3 the channel 1 high byte.
- R7: A clock edge with `rd_en` high and `rd_addr` 0 (or 2) copies that channel's result high byte into its holding register. Address 1 (or 3) returns the holding register, and later transfers do not change it.
- R8: While `enable` is low the counters stay at zero, no transfer occurs, `xfer_done` stays low and the result registers keep their values. After `enable` rises, a fresh full window starts.
- R9: After reset, both result registers and both holding registers read zero and `xfer_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the integration windows when high |
| pulse_ch0 | input | 1 | Event input, channel 0 |
| pulse_ch1 | input | 1 | Event input, channel 1 |
| integ_len | input | LEN_W | Window length in clock cycles |
| rd_en | input | 1 | Read strobe; low-byte reads capture the high byte |
| rd_addr | input | 2 | Byte select |
| rd_data | output | BYTE_W | Selected result byte |
| xfer_done | output | 1 | One-cycle marker of a completed transfer |

## Verification
Directed runs separate the two channels by giving them different pulse densities in the same window, so a crossed or skewed channel shows up as a wrong total. Back-to-back windows show whether a cycle is lost or a count leaks between windows. A length change in the middle of a window tells a length sampled at window start apart from one sampled live. A window longer than the counter range shows wrapping against saturation. Reads split across a transfer and an enable drop in the middle of a window exercise the capture and hold paths. A long random run with random reads, lengths and enable gaps is compared every cycle against a bench model.

// File: rtl/dis_pkg.sv
package dis_pkg;

  typedef enum logic [1:0] {
    SEL_C0_LO = 2'd0,
    SEL_C0_HI = 2'd1,
    SEL_C1_LO = 2'd2,
    SEL_C1_HI = 2'd3
  } rd_sel_e;

  // add a single event to a count, clamping at the given ceiling
  function automatic logic [31:0] sat_inc(input logic [31:0] cur, input logic ev,
                                          input logic [31:0] ceil);
    if (!ev || cur >= ceil) return cur;
    return cur + 32'd1;
  endfunction

  // a programmed length of zero behaves as a single-cycle window
  function automatic logic [31:0] eff_len(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

endpackage

// File: rtl/dis_win_timer.sv
module dis_win_timer #(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] len_in,
  output logic             win_end,
  output logic             xfer_done,
  output logic [LEN_W-1:0] cnt_q,
  output logic [LEN_W-1:0] len_q
);
  import dis_pkg::*;

  logic [LEN_W-1:0] len_next;

  assign len_next = LEN_W'(eff_len(32'(len_in)));
  assign win_end  = enable && (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      len_q     <= LEN_W'(1);
      xfer_done <= 1'b0;
    end else if (!enable) begin
      cnt_q     <= '0;
      len_q     <= len_next;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= win_end;
      if (win_end) begin
        cnt_q <= '0;
        len_q <= len_next;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/dis_chan_acc.sv
module dis_chan_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pulse,
  input  logic             win_end,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] data_q
);
  import dis_pkg::*;

  localparam logic [ACC_W-1:0] CEIL = {ACC_W{1'b1}};

  logic [ACC_W-1:0] sum;

  assign sum = ACC_W'(sat_inc(32'(acc_q), pulse, 32'(CEIL)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      data_q <= '0;
    end else if (!enable) begin
      acc_q  <= '0;
    end else if (win_end) begin
      data_q <= sum;
      acc_q  <= '0;
    end else begin
      acc_q  <= sum;
    end
  end
endmodule

// File: rtl/dis_rd_port.sv
module dis_rd_port #(
  parameter int BYTE_W = 8,
  parameter int NCH    = 2,
  parameter int ACC_W  = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0][ACC_W-1:0] data_q,
  input  logic                      rd_en,
  input  logic [1:0]                rd_addr,
  output logic [BYTE_W-1:0]         rd_data
);
  import dis_pkg::*;

  logic [NCH-1:0][BYTE_W-1:0] hold_q;
  rd_sel_e sel;

  assign sel = rd_sel_e'(rd_addr);

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_q[c] <= '0;
      else if (rd_en && !rd_addr[0] && (int'(rd_addr[1]) == c))
        hold_q[c] <= data_q[c][ACC_W-1:BYTE_W];
    end
  end

  always_comb begin
    case (sel)
      SEL_C0_LO: rd_data = data_q[0][BYTE_W-1:0];
      SEL_C0_HI: rd_data = hold_q[0];
      SEL_C1_LO: rd_data = data_q[1][BYTE_W-1:0];
      default:   rd_data = hold_q[1];
    endcase
  end
endmodule

// File: rtl/dual_integ_seq.sv
module dual_integ_seq #(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pulse_ch0,
  input  logic              pulse_ch1,
  input  logic [LEN_W-1:0]  integ_len,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              xfer_done
);
  localparam int ACC_W = 2 * BYTE_W;
  localparam int NCH   = 2;

  logic                      win_end;
  logic [LEN_W-1:0]          cnt_q;
  logic [LEN_W-1:0]          len_q;
  logic [NCH-1:0]            pulse_v;
  logic [NCH-1:0][ACC_W-1:0] acc_q;
  logic [NCH-1:0][ACC_W-1:0] data_q;

  assign pulse_v = {pulse_ch1, pulse_ch0};

  dis_win_timer #(.LEN_W(LEN_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .len_in    (integ_len),
    .win_end   (win_end),
    .xfer_done (xfer_done),
    .cnt_q     (cnt_q),
    .len_q     (len_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dis_chan_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .pulse   (pulse_v[c]),
      .win_end (win_end),
      .acc_q   (acc_q[c]),
      .data_q  (data_q[c])
    );
  end

  dis_rd_port #(.BYTE_W(BYTE_W), .NCH(NCH), .ACC_W(ACC_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_q  (data_q),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dis_seq_chk.sv
module dis_seq_chk #(
  parameter int ACC_W = 16,
  parameter int LEN_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                win_end,
  input logic                xfer_done,
  input logic [LEN_W-1:0]    cnt_q,
  input logic [LEN_W-1:0]    len_q,
  input logic [1:0][ACC_W-1:0] acc_q,
  input logic [1:0][ACC_W-1:0] data_q
);
  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  p_cnt_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);

  p_update_marked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q != $past(data_q)) |-> xfer_done);

  p_fresh_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (acc_q[0] == '0 && acc_q[1] == '0));

  p_sat_ch0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !win_end && acc_q[0] == FULL) |=> (acc_q[0] == FULL));

  p_sat_ch1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !win_end && acc_q[1] == FULL) |=> (acc_q[1] == FULL));

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    len_q != '0);

  p_idle_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(data_q) && !xfer_done && acc_q[0] == '0 && acc_q[1] == '0));
endmodule

bind dual_integ_seq dis_seq_chk #(.ACC_W(2 * BYTE_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .win_end   (win_end),
  .xfer_done (xfer_done),
  .cnt_q     (cnt_q),
  .len_q     (len_q),
  .acc_q     (acc_q),
  .data_q    (data_q)
);

// File: tb/dual_integ_seq_bench.sv
module dual_integ_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 20;
  localparam int BYTE_W     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic p0 = 1'b0;
  logic p1 = 1'b0;
  logic rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [LEN_W-1:0] integ_len = LEN_W'(1);
  logic [BYTE_W-1:0] rd_data;
  logic xfer_done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_integ_seq #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_dual_integ_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pulse_ch0 (p0),
    .pulse_ch1 (p1),
    .integ_len (integ_len),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .xfer_done (xfer_done)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_done = 0;
  string ph = "R9";

  int m_acc[2];
  int m_data[2];
  int m_hold[2];
  int m_cnt;
  int m_len;
  int m_done;

  function automatic int b_len(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int b_clamp(int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic int b_byte(int a);
    case (a)
      0: return m_data[0] % 256;
      1: return m_hold[0];
      2: return m_data[1] % 256;
      default: return m_hold[1];
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit en, bit a, bit b, int len, bit re, int ad);
    @(negedge clk);
    enable = en; p0 = a; p1 = b; integ_len = LEN_W'(len);
    rd_en = re; rd_addr = 2'(ad);
    #1;
    chk({ph, " rd_data"}, int'(rd_data), b_byte(ad));
    if (re && ad == 0) m_hold[0] = m_data[0] / 256;
    if (re && ad == 2) m_hold[1] = m_data[1] / 256;
    if (!en) begin
      m_acc[0] = 0; m_acc[1] = 0; m_cnt = 0; m_len = b_len(len); m_done = 0;
    end else begin
      m_acc[0] = b_clamp(m_acc[0] + int'(a));
      m_acc[1] = b_clamp(m_acc[1] + int'(b));
      if (m_cnt == m_len - 1) begin
        m_data[0] = m_acc[0]; m_data[1] = m_acc[1];
        m_acc[0] = 0; m_acc[1] = 0; m_cnt = 0; m_len = b_len(len); m_done = 1;
      end else begin
        m_cnt++; m_done = 0;
      end
    end
    @(posedge clk);
    #1;
    chk({ph, " xfer_done"}, int'(xfer_done), m_done);
    if (xfer_done) n_done++;
  endtask

  task automatic peek(int ad, output int v);
    rd_en = 1'b0; rd_addr = 2'(ad);
    #1;
    v = int'(rd_data);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog: got 0 expected 1 (run did not end)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v;
    int d0;
    int t;
    void'($urandom(32'd20240611));
    m_acc[0] = 0; m_acc[1] = 0; m_data[0] = 0; m_data[1] = 0;
    m_hold[0] = 0; m_hold[1] = 0; m_cnt = 0; m_len = 1; m_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R9: everything reads zero out of reset
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk("R9 reset byte", int'(rd_data), 0);
    end
    chk("R9 reset xfer_done", int'(xfer_done), 0);

    // R1, R2: shared window of 4, channels at different densities
    ph = "R1";
    step(0, 0, 0, 4, 0, 0);
    t = n_done;
    for (int k = 0; k < 4; k++) step(1, 1, (k % 2) == 0, 4, 0, 0);
    chk("R2 one transfer per window", n_done - t, 1);
    peek(0, v); chk("R1 ch0 total", v, 4);
    peek(2, v); chk("R1 ch1 total", v, 2);

    // R3: back-to-back window, no lost cycle, counts do not leak
    ph = "R3";
    for (int k = 0; k < 4; k++) step(1, 0, 1, 4, 0, 0);
    chk("R3 second transfer", n_done - t, 2);
    peek(0, v); chk("R3 ch0 fresh", v, 0);
    peek(2, v); chk("R3 ch1 fresh", v, 4);

    // R5: length change mid-window applies to the following window
    ph = "R5";
    step(0, 0, 0, 6, 0, 0);
    for (int k = 1; k <= 10; k++) begin
      step(1, 1, 0, (k <= 2) ? 6 : 2, 0, 0);
      chk("R5 transfer timing", int'(xfer_done), int'(k == 6 || k == 8 || k == 10));
    end
    peek(0, v); chk("R5 short window total", v, 2);

    // R7: capture survives a transfer between low and high reads
    ph = "R7";
    step(0, 0, 0, 300, 0, 0);
    for (int k = 0; k < 300; k++) step(1, 1, 1, 300, 0, 0);
    step(1, 0, 0, 300, 1, 0);
    for (int k = 0; k < 299; k++) step(1, 0, 0, 300, 0, 0);
    peek(0, v); chk("R7 new low byte", v, 0);
    peek(1, v); chk("R7 captured high byte", v, 1);
    step(0, 0, 0, 300, 1, 2);
    peek(3, v); chk("R7 ch1 high after capture", v, 0);

    // R8: enable drop mid-window freezes results, restart is a full window
    ph = "R8";
    step(0, 0, 0, 10, 0, 0);
    for (int k = 0; k < 10; k++) step(1, 1, 0, 10, 0, 0);
    peek(0, d0);
    for (int k = 0; k < 4; k++) step(1, 1, 0, 10, 0, 0);
    t = n_done;
    for (int k = 0; k < 5; k++) step(0, 1, 1, 10, 0, 0);
    chk("R8 no transfer while off", n_done - t, 0);
    peek(0, v); chk("R8 results held", v, d0);
    for (int k = 0; k < 10; k++) step(1, 1, 0, 10, 0, 0);
    peek(0, v); chk("R8 fresh window after enable", v, 10);

    // R4: window longer than the counter range
    ph = "R4";
    step(0, 0, 0, 70000, 0, 0);
    for (int k = 0; k < 70000; k++) step(1, 1, 0, 70000, 0, 0);
    step(0, 0, 0, 70000, 1, 0);
    peek(0, v); chk("R4 saturated low", v, 255);
    peek(1, v); chk("R4 saturated high", v, 255);
    peek(2, v); chk("R4 idle channel", v, 0);

    // R6: random traffic, reads and lengths against the bench model
    ph = "R6";
    begin
      int len_r;
      len_r = 1 + int'($urandom % 20);
      for (int k = 0; k < 4000; k++) begin
        if ($urandom % 50 == 0) len_r = int'($urandom % 24);
        step(($urandom % 10) != 0, $urandom % 2 == 0, $urandom % 3 == 0, len_r,
             $urandom % 4 == 0, int'($urandom % 4));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule